// File: doc/BRIEF.md
# Serial-Load Shift Register with Latched Tri-State Outputs

This block accepts a serial bit stream into an 8-stage shift stage clocked by its own shift clock. A second, independent storage clock copies the whole shift stage into an 8-bit storage latch, which drives the parallel outputs through tri-state buffers under an active-low output enable. Because the latch is loaded separately, the parallel outputs stay steady while a new word is being shifted in, and they change in one step when the storage clock fires.

An active-low clear acts at once, without a clock, and zeroes only the shift stage. The storage latch keeps its word until the next storage-clock edge. The last shift stage is always brought out on a serial cascade pin. Several blocks can therefore be chained: each serial output feeds the next serial input, all shift clocks are tied together, and all storage clocks are tied together.

Top module: `ser_latch_reg`

## Requirements
- R1: The shift stage and the storage latch are each 8 bits wide. After a clear followed by one storage-clock rising edge, the parallel outputs read 8'h00 and the serial output reads 0.
- R2: On each rising edge of `shift_clk`, the value on `ser_in` enters shift position 0 and every position k moves to position k+1.
- R3: On each rising edge of `store_clk`, the storage latch takes a copy of all 8 shift positions. Shift-clock edges with no storage-clock edge leave the parallel outputs unchanged.
- R4: Driving `clr_n` low sets every shift position to 0 at once, without waiting for any clock edge.
- R5: A clear leaves the storage latch unchanged. The parallel outputs keep their latched word until the next `store_clk` rising edge.
- R6: `ser_out` always shows shift position 7, so a second block whose `ser_in` is fed from it receives bits 8 shift edges later. With two chained blocks and 16 bits shifted most-significant first, the downstream block holds bits 15:8 and the upstream block holds bits 7:0.
- R7: When `oe_n` is high, all 8 bits of `par_q` are high-impedance. When it is low, `par_q` drives the storage latch. `ser_out` is driven whatever the level of `oe_n`.
- R8: If `shift_clk` and `store_clk` rise at the same instant, the storage latch captures the shift contents as they were before that shift.
- R9: Bit k of `par_q` comes from shift position k. Bit 0 is the most recently shifted-in bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift-stage clock, rising edge |
| store_clk | input | 1 | Storage-latch clock, rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of the shift stage |
| oe_n | input | 1 | Active-low output enable for `par_q` |
| ser_in | input | 1 | Serial data input to shift position 0 |
| par_q | output | 8 | Tri-state parallel outputs from the storage latch |
| ser_out | output | 1 | Serial cascade output (shift position 7) |

## Verification
The hardest case to produce from the ports is the two clocks rising at exactly the same instant. A second hard case is a clear arriving while the latch holds a non-zero word. For the first, the bench raises `shift_clk` and `store_clk` in a single statement block, with a `ser_in` value that would change the latched word if the shift were seen first. For the second, it latches a known pattern, pulses `clr_n` with no clock activity, and reads `par_q` and `ser_out` before and after the next storage edge. Pull resistors on the bench nets make high-impedance outputs visible as a known level.

// File: rtl/slr_pkg.sv
// Package: shared constants for the serial-load latched register.
// Assumes: nothing beyond standard SystemVerilog.
package slr_pkg;
    parameter int unsigned SLR_DEF_WIDTH = 8;
endpackage

// File: rtl/slr_shift_stage.sv
// Module: slr_shift_stage
// Serial-in shift chain. Position 0 takes ser_in on each rising shift edge,
// and every position k moves to k+1. The active-low clear is asynchronous.
// Assumes: WIDTH >= 2.
module slr_shift_stage #(
    parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
    input  logic             shift_clk,
    input  logic             clr_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stage_q
);
    localparam int unsigned LAST = WIDTH - 1;

    // One flop per position; position 0 is fed from the serial input.
    for (genvar k = 0; k <= LAST; k++) begin : g_pos
        logic next_d;
        if (k == 0) begin : g_head
            assign next_d = ser_in;
        end else begin : g_body
            assign next_d = stage_q[k-1];
        end

        // Purpose: capture the upstream bit, or clear at once.
        always_ff @(posedge shift_clk or negedge clr_n) begin
            if (!clr_n) stage_q[k] <= 1'b0;
            else        stage_q[k] <= next_d;
        end
    end
endmodule

// File: rtl/slr_store_stage.sv
// Module: slr_store_stage
// Storage latch. It copies the shift word on each rising storage edge.
// It has no clear: the word is kept until the next storage edge.
// Assumes: shift_word is stable around the storage edge, or changes in the
// same time step (the value before the edge is then taken).
module slr_store_stage #(
    parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
    input  logic             store_clk,
    input  logic [WIDTH-1:0] shift_word,
    output logic [WIDTH-1:0] store_q
);
    // Purpose: take a copy of the whole shift word.
    always_ff @(posedge store_clk) begin
        store_q <= shift_word;
    end
endmodule

// File: rtl/slr_out_drive.sv
// Module: slr_out_drive
// Tri-state driver for the parallel outputs. While out_en_n is high,
// every bit floats.
// Assumes: the pins are wired to a net that can resolve 'z.
module slr_out_drive #(
    parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
    input  logic             out_en_n,
    input  logic [WIDTH-1:0] data_in,
    output tri   [WIDTH-1:0] pins
);
    // Purpose: drive the latched word or release the pins.
    for (genvar k = 0; k < WIDTH; k++) begin : g_buf
        assign pins[k] = out_en_n ? 1'bz : data_in[k];
    end
endmodule

// File: rtl/ser_latch_reg.sv
// Module: ser_latch_reg (top)
// Serial-in shift stage, an independently clocked storage latch, tri-state
// parallel outputs, and a serial cascade output from the last shift stage.
// Assumes: the two clocks are independent and may coincide.
module ser_latch_reg #(
    parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             clr_n,
    input  logic             oe_n,
    input  logic             ser_in,
    output tri   [WIDTH-1:0] par_q,
    output logic             ser_out
);
    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] store_q;

    slr_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .shift_clk (shift_clk),
        .clr_n     (clr_n),
        .ser_in    (ser_in),
        .stage_q   (shift_q)
    );

    slr_store_stage #(.WIDTH(WIDTH)) u_store (
        .store_clk  (store_clk),
        .shift_word (shift_q),
        .store_q    (store_q)
    );

    slr_out_drive #(.WIDTH(WIDTH)) u_drive (
        .out_en_n (oe_n),
        .data_in  (store_q),
        .pins     (par_q)
    );

    // Purpose: cascade output from the last shift position.
    assign ser_out = shift_q[LAST];
endmodule

// File: rtl/ser_latch_reg_chk.sv
// Module: ser_latch_reg_chk
// Assertion checker, bound into ser_latch_reg.
// Assumes: it sees the internal shift and storage words through the bind.
module ser_latch_reg_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             shift_clk,
    input logic             store_clk,
    input logic             clr_n,
    input logic             ser_in,
    input logic             ser_out,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] store_q
);
    // Purpose: mark that a shift edge has occurred since the last clear.
    logic sh_armed;
    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) sh_armed <= 1'b0;
        else        sh_armed <= 1'b1;
    end

    // Purpose: mark that a storage edge has occurred.
    logic st_armed = 1'b0;
    always_ff @(posedge store_clk) begin
        st_armed <= 1'b1;
    end

    AST_SHIFT_ENTRY: assert property (@(posedge shift_clk) disable iff (!clr_n)
        sh_armed |-> shift_q[0] == $past(ser_in)); // R2

    AST_SHIFT_ADVANCE: assert property (@(posedge shift_clk) disable iff (!clr_n)
        sh_armed |-> shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0])); // R2

    AST_STORE_COPY: assert property (@(posedge store_clk) disable iff (!clr_n)
        st_armed |-> store_q == $past(shift_q)); // R3

    AST_SER_OUT_LAST: assert property (@(posedge shift_clk) disable iff (!clr_n)
        sh_armed |-> ser_out == $past(shift_q[WIDTH-2])); // R6
endmodule

bind ser_latch_reg ser_latch_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .shift_clk (shift_clk),
    .store_clk (store_clk),
    .clr_n     (clr_n),
    .ser_in    (ser_in),
    .ser_out   (ser_out),
    .shift_q   (shift_q),
    .store_q   (store_q)
);

// File: tb/ser_latch_reg_tb.sv
// Bench: two chained blocks sharing their clocks. A vector table is walked
// first, then directed tests cover clear, enable and coincident edges.
module ser_latch_reg_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz timing reference

    logic shift_clk = 1'b0, store_clk = 1'b0, clr_n = 1'b0;
    logic oe_a_n = 1'b0, oe_b_n = 1'b0, ser_in = 1'b0;
    wire  [7:0] q_a, q_b;
    wire  link, ser_b;

    pullup   pu_a[7:0] (q_a);   // a floating upstream bus reads 8'hFF
    pulldown pd_b[7:0] (q_b);   // a floating downstream bus reads 8'h00

    ser_latch_reg u_dut (
        .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n),
        .oe_n(oe_a_n), .ser_in(ser_in), .par_q(q_a), .ser_out(link));

    ser_latch_reg u_dut_b (
        .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n),
        .oe_n(oe_b_n), .ser_in(link), .par_q(q_b), .ser_out(ser_b));

    int n_run = 0, n_fail = 0;

    typedef struct packed { logic [15:0] word; logic [7:0] exp_a; logic [7:0] exp_b; } vec_t;
    localparam vec_t VECS [6] = '{
        '{16'h0000, 8'h00, 8'h00},
        '{16'hFFFF, 8'hFF, 8'hFF},
        '{16'hA55A, 8'h5A, 8'hA5},
        '{16'h8001, 8'h01, 8'h80},
        '{16'h1234, 8'h34, 8'h12},
        '{16'hC3E7, 8'hE7, 8'hC3}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk) ser_in = b;
        @(negedge clk) shift_clk = 1'b1;
        @(negedge clk) shift_clk = 1'b0;
    endtask

    task automatic store_pulse();
        @(negedge clk) store_clk = 1'b1;
        @(negedge clk) store_clk = 1'b0;
    endtask

    task automatic shift_word16(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    endtask

    initial begin : watchdog
        #1000000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        store_pulse();
        @(negedge clk);
        // R1: reset state after clear and one storage edge
        check("R1 outputs A", q_a, 8'h00);
        check("R1 outputs B", q_b, 8'h00);
        check("R1 ser_out", {7'd0, ser_b}, 8'h00);

        // R6 R9: chained vectors, bits shifted most-significant first
        foreach (VECS[v]) begin
            shift_word16(VECS[v].word);
            check("R3 no change before store", q_a, v == 0 ? 8'h00 : VECS[v-1].exp_a);
            store_pulse();
            @(negedge clk);
            check("R6 R9 upstream word", q_a, VECS[v].exp_a);
            check("R6 downstream word", q_b, VECS[v].exp_b);
        end

        // R2: single shift moves word left, new bit at position 0
        shift_word16(16'h0081);      // A=81
        shift_bit(1'b0);             // A=02, B gets bit 1 from A[7]
        store_pulse(); @(negedge clk);
        check("R2 shift advance", q_a, 8'h02);

        // R4 R5: clear with a latched pattern
        shift_word16(16'h00A5); store_pulse(); @(negedge clk);
        check("R3 latch pattern", q_a, 8'hA5);
        check("R6 ser_out before clear", {7'd0, link}, 8'h01);
        @(negedge clk) clr_n = 1'b0;
        #1;
        check("R4 clear async", {7'd0, link}, 8'h00);
        @(negedge clk) clr_n = 1'b1;
        @(negedge clk);
        check("R5 store kept A", q_a, 8'hA5);
        store_pulse(); @(negedge clk);
        check("R5 zeros after store", q_a, 8'h00);

        // R7: output enable
        shift_word16(16'h0000); store_pulse();
        @(negedge clk) oe_a_n = 1'b1;
        #1 check("R7 hi-z A reads pullup", q_a, 8'hFF);
        shift_word16(16'h3C80); store_pulse();
        @(negedge clk) oe_b_n = 1'b1;
        #1 check("R7 hi-z B reads pulldown", q_b, 8'h00);
        check("R7 ser_out driven while disabled", {7'd0, link}, 8'h01);
        @(negedge clk) begin oe_a_n = 1'b0; oe_b_n = 1'b0; end
        #1 check("R7 enabled B", q_b, 8'h3C);

        // R8: coincident edges capture pre-shift contents
        shift_word16(16'h0055); store_pulse();
        @(negedge clk) ser_in = 1'b1;
        @(negedge clk) begin shift_clk = 1'b1; store_clk = 1'b1; end
        @(negedge clk) begin shift_clk = 1'b0; store_clk = 1'b0; end
        @(negedge clk);
        check("R8 coincident edge keeps old", q_a, 8'h55);
        store_pulse(); @(negedge clk);
        check("R8 next store sees shift", q_a, 8'hAB);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule